// File: doc/BRIEF.md
# Control-Track Pulse Duty Discriminator

This block watches a playback control-track pulse train and classifies every complete pulse period by the fraction of the period that the signal spends high. The input is brought into the system clock domain first. Two counters then measure the high time and the whole period, from one rising edge to the next. At the rising edge that closes a period, the block compares the measured ratio with a threshold picked by a mode input. It registers a one-bit result and raises a one-cycle valid strobe.

The two modes give the flag opposite meanings. In index/address detect mode the threshold is 44 %, and the flag marks long-high pulses, which are read as 0 pulses. Short-high pulses, read as 1 pulses, clear the flag. In mark detect mode the threshold is 66 %, and a flag of 0 means that a mark (a very long high phase) was seen. A period that outlasts the counter range is thrown away, and no strobe is issued for it.

Top module: `ctl_duty_disc`

## Requirements
- R1: While reset (`rst_ni` low) is applied, `flag_o` and `valid_o` are 0 at the following clock edge.
- R2: With `mode_i` = 0 (index/address detect), a completed period whose high count H and period count P satisfy H*100 > 44*P yields `flag_o` = 1.
- R3: With `mode_i` = 0, a completed period with H*100 <= 44*P, equality included, yields `flag_o` = 0.
- R4: With `mode_i` = 1 (mark detect), a completed period with H*100 > 66*P yields `flag_o` = 0, which signals a detected mark.
- R5: With `mode_i` = 1, a completed period with H*100 <= 66*P yields `flag_o` = 1.
- R6: `valid_o` is high for exactly one cycle for each completed period. A period runs from one synchronized rising edge of `ctl_i` to the next. The first rising edge after reset, and the first rising edge after a discarded period, only start a measurement and give no strobe.
- R7: Periods of up to 2^CNT_W-1 clock cycles are measured. A longer period is discarded, and no `valid_o` strobe is issued for it.
- R8: `flag_o` changes only in a cycle where `valid_o` is high. At all other times it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 1 | Raw control-track pulse input, asynchronous to `clk_i` |
| mode_i | input | 1 | 0 = index/address detect (44 %), 1 = mark detect (66 %) |
| flag_o | output | 1 | Duty discrimination result of the last completed period |
| valid_o | output | 1 | One-cycle strobe marking an update of `flag_o` |

## Verification
The hardest case is a single rising edge that both closes a period and must be judged against counter saturation. When the period equals exactly the counter maximum, the same edge has to produce a strobe. One cycle longer, and that edge only restarts measurement. The bench drives both lengths back to back with an 8-bit counter and checks, through an expected-result queue, that the first period gives a strobe and the second gives none. Duty sweeps over every high time at several period lengths test both threshold boundaries, including exact equality.

// File: rtl/ctl_duty_pkg.sv
package ctl_duty_pkg;

    typedef enum logic {
        MODE_INDEX = 1'b0,
        MODE_MARK  = 1'b1
    } disc_mode_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_st_t;

    typedef struct packed {
        logic flag;
        logic valid;
    } result_st_t;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync
    import ctl_duty_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;

endmodule

// File: rtl/ctl_period_counter.sv
module ctl_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             done_o,
    output logic [CNT_W-1:0] high_o,
    output logic [CNT_W-1:0] per_o,
    output logic             sat_o
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             armed;
        logic             in_high;
        logic             sat;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (rise_i) begin
            done_o       = st_q.armed & ~st_q.sat;
            st_d.armed   = 1'b1;
            st_d.in_high = 1'b1;
            st_d.sat     = 1'b0;
            st_d.per     = ONE;
            st_d.high    = ONE;
        end else begin
            if (st_q.per == MAXV) st_d.sat = 1'b1;
            else                  st_d.per = st_q.per + ONE;
            if (fall_i)                                 st_d.in_high = 1'b0;
            else if (st_q.in_high && st_q.high != MAXV) st_d.high    = st_q.high + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign high_o = st_q.high;
    assign per_o  = st_q.per;
    assign sat_o  = st_q.sat;

endmodule

// File: rtl/ctl_duty_compare.sv
module ctl_duty_compare
    import ctl_duty_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int THR_INDEX = 44,
    parameter int THR_MARK  = 66
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  disc_mode_e       mode_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [CNT_W-1:0] per_i,
    output logic             flag_o,
    output logic             valid_o
);

    localparam int PW = CNT_W + 7;

    result_st_t      st_d, st_q;
    logic [PW-1:0]   lhs, rhs, thr;
    logic            above;

    always_comb begin
        thr   = (mode_i == MODE_MARK) ? PW'(THR_MARK) : PW'(THR_INDEX);
        lhs   = PW'(high_i) * PW'(100);
        rhs   = PW'(per_i) * thr;
        above = lhs > rhs;
        st_d       = st_q;
        st_d.valid = done_i;
        if (done_i) st_d.flag = (mode_i == MODE_MARK) ? ~above : above;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/ctl_duty_disc.sv
module ctl_duty_disc
    import ctl_duty_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int THR_INDEX = 44,
    parameter int THR_MARK  = 66
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ctl_i,
    input  logic mode_i,
    output logic flag_o,
    output logic valid_o
);

    logic             rise_w, fall_w, done_w, sat_w;
    logic [CNT_W-1:0] high_w, per_w;
    disc_mode_e       mode_w;

    assign mode_w = disc_mode_e'(mode_i);

    ctl_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ctl_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    ctl_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (rise_w),
        .fall_i (fall_w),
        .done_o (done_w),
        .high_o (high_w),
        .per_o  (per_w),
        .sat_o  (sat_w)
    );

    ctl_duty_compare #(
        .CNT_W    (CNT_W),
        .THR_INDEX(THR_INDEX),
        .THR_MARK (THR_MARK)
    ) u_cmp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .done_i (done_w),
        .mode_i (mode_w),
        .high_i (high_w),
        .per_i  (per_w),
        .flag_o (flag_o),
        .valid_o(valid_o)
    );

endmodule

// File: rtl/ctl_duty_disc_chk.sv
module ctl_duty_disc_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic flag_o,
    input logic valid_o,
    input logic rise_i,
    input logic sat_i
);

    // R1
    rst_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!valid_o && !flag_o));

    // R6
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R6
    strobe_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(rise_i));

    // R7
    no_sat_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !$past(sat_i));

    // R8
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(flag_o));

endmodule

bind ctl_duty_disc ctl_duty_disc_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_o (flag_o),
    .valid_o(valid_o),
    .rise_i (rise_w),
    .sat_i  (sat_w)
);

// File: tb/tb_ctl_duty_disc.sv
`timescale 1ns/1ps
module tb_ctl_duty_disc;

    localparam int CW   = 8;
    localparam int MAXP = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl = 1'b0;
    logic mode = 1'b0;
    logic flag, valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit exp_q[$];
    bit last_flag = 1'b0;
    bit prev_valid = 1'b0;
    bit mon_en = 1'b0;

    always #5 clk = ~clk;

    ctl_duty_disc #(.CNT_W(CW)) dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .ctl_i  (ctl),
        .mode_i (mode),
        .flag_o (flag),
        .valid_o(valid)
    );

    function automatic bit expect_flag(int h, int p, bit m);
        bit above;
        above = (h * 100) > ((m ? 66 : 44) * p);
        return m ? !above : above;
    endfunction

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (valid) begin
                checks++;
                if (prev_valid) begin
                    errors++;
                    $display("FAIL R6 strobe longer than one cycle: actual valid=1 expected valid=0");
                end
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected strobe: actual valid=1 expected valid=0");
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    checks++;
                    if (flag !== e) begin
                        errors++;
                        $display("FAIL %s flag: actual %0b expected %0b (mode %0b)",
                                 mode ? (e ? "R5" : "R4") : (e ? "R2" : "R3"), flag, e, mode);
                    end
                    last_flag = e;
                end
            end else begin
                checks++;
                if (flag !== last_flag) begin
                    errors++;
                    $display("FAIL R8 flag changed without strobe: actual %0b expected %0b",
                             flag, last_flag);
                end
            end
            prev_valid = valid;
        end
    end

    task automatic pulse(int h, int l, bit push);
        ctl = 1'b1;
        repeat (h) @(negedge clk);
        ctl = 1'b0;
        repeat (l) @(negedge clk);
        if (push) exp_q.push_back(expect_flag(h, h + l, mode));
    endtask

    task automatic sweep_period(int p);
        for (int h = 1; h < p; h++) pulse(h, p - h, 1'b1);
    endtask

    task automatic close_block();
        // closing rise completes the last period, then a long gap saturates (R7)
        pulse(1, 300, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (flag !== 1'b0 || valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual flag=%0b valid=%0b expected 0 0", flag, valid);
        end
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (300) @(negedge clk);

        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            sweep_period(100);   // R2 R3 R4 R5 equality at 44 and 66
            sweep_period(25);
            sweep_period(7);
            pulse(1, 1, 1'b1);
            pulse(112, MAXP - 112, 1'b1);
            pulse(113, MAXP - 113, 1'b1);
            pulse(169, MAXP - 169, 1'b1);
            pulse(168, MAXP - 168, 1'b1);
            // R7: one cycle beyond the counter range is discarded
            pulse(100, MAXP + 1 - 100, 1'b0);
            pulse(10, MAXP - 10, 1'b1);
            close_block();
        end

        repeat (10) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing strobes: actual %0d pending expected 0", exp_q.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule